// File: doc/BRIEF.md
# Bus Access Watchpoint Unit

This block watches the stream of memory accesses that pass through a memory arbiter and flags the ones that fall into ranges of interest. It holds a parameterised number of watchpoints (four by default). Each watchpoint is programmed with a lower and an upper address bound, a mask of the access kinds it traps (for example, writes only) and a mask of the arbiter clients it cares about. An access that satisfies all three conditions in the cycle of its valid strobe is a hit.

On a hit the watchpoint records which of its watched clients took part, the lowest-numbered of those clients, the address, the access kind and the size. The record then stays frozen until it is released by its own acknowledge. Separately, every hit sets a pending interrupt bit. That bit is gated by a per-watchpoint enable mask into a status vector and a single interrupt line. A priority output names the lowest-numbered watchpoint in the status vector, so the handler can take them in order. Configuration arrives through a narrow write port that carries a watchpoint number, a field code and a data word. Captured records are read through a select input.

Top module: `bus_watch_unit`

## Requirements
- R1: After reset every capture is released with all captured fields zero, every pending bit and every enable bit is zero, `irq` is low, and all bounds and masks are zero, so no access can hit.
- R2: The address condition holds when lower bound <= `acc_addr` < upper bound, compared unsigned: the lower bound is inclusive and the upper bound is exclusive.
- R3: The client condition holds when `acc_clients & client_mask` is nonzero. The captured client field is that AND, and the captured first client is the index of its lowest set bit.
- R4: The kind condition holds when bit `acc_op` of the watchpoint's kind mask is set.
- R5: No watchpoint hits in a cycle where `acc_valid` is low, whatever the other access inputs are.
- R6: The record of a hit is visible on the read port from the clock edge that samples the access. While a record is held, later hits leave it unchanged.
- R7: A `cap_ack[i]` pulse releases watchpoint i's record and zeroes its fields. If watchpoint i hits in the same cycle, the new access is captured instead.
- R8: Every hit sets pending bit i, whether or not the record is held. An `irq_ack[i]` pulse clears the bit, except when a hit on i comes in the same cycle, in which case the bit stays set.
- R9: `irq_status` is the pending vector ANDed with the enable mask, and `irq` is the OR of `irq_status`. Changing one enable bit changes only that watchpoint's status bit.
- R10: `irq_next_valid` is high when `irq_status` is nonzero, and `irq_next_idx` is the index of the lowest set bit of `irq_status` (watchpoint 0 ahead of 1, 2 and 3).
- R11: When `cfg_we` is high, `cfg_field` selects what is written: 0 the lower bound, 1 the upper bound, 2 the kind mask (low bits of `cfg_wdata`), 3 the client mask (low bits), and 4 the enable mask (low NWP bits, `cfg_wp` ignored). Other codes and out-of-range `cfg_wp` values change nothing. A write takes effect for accesses in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wp | input | WPW (2) | Watchpoint addressed by the write |
| cfg_field | input | 3 | Field code of the write |
| cfg_wdata | input | AW (32) | Write data |
| acc_valid | input | 1 | Access valid strobe |
| acc_addr | input | AW (32) | Access address |
| acc_clients | input | NCLI (16) | Bitmask of clients taking part in the access |
| acc_op | input | OPW (2) | Access kind index |
| acc_size | input | SZW (4) | Access size |
| cap_ack | input | NWP (4) | Per-watchpoint capture release pulses |
| irq_ack | input | NWP (4) | Per-watchpoint pending-interrupt clear pulses |
| rd_sel | input | WPW (2) | Watchpoint whose record is shown |
| rd_held | output | 1 | Selected record is held |
| rd_clients | output | NCLI (16) | Captured matching clients |
| rd_addr | output | AW (32) | Captured address |
| rd_op | output | OPW (2) | Captured access kind |
| rd_first | output | CIW (4) | Captured lowest matching client index |
| rd_size | output | SZW (4) | Captured size |
| irq_status | output | NWP (4) | Enabled pending bits |
| irq | output | 1 | Interrupt request |
| irq_next_valid | output | 1 | Some status bit is set |
| irq_next_idx | output | WPW (2) | Lowest-numbered watchpoint in the status |

## Verification
The hardest situations to reach from the ports are collisions in a single cycle: a hit that lands together with its own capture release or interrupt clear, and several watchpoints hitting at once while their enables are being rewritten. Directed steps set up overlapping ranges on two watchpoints and fire the acknowledges in the same cycle as a hit. A long random phase then works over an eight-bit corner of the address space with sparse client masks and frequent reprogramming. In that phase empty and overlapping ranges, bound-equal addresses and same-cycle collisions come up often, and a cycle-accurate bench model checks every record and status bit after each edge.

// File: rtl/bwu_pkg.sv
package bwu_pkg;

   // Field codes of the configuration write port
   localparam logic [2:0] FLD_LO    = 3'd0;
   localparam logic [2:0] FLD_HI    = 3'd1;
   localparam logic [2:0] FLD_OPS   = 3'd2;
   localparam logic [2:0] FLD_CLI   = 3'd3;
   localparam logic [2:0] FLD_IMASK = 3'd4;

endpackage

// File: rtl/bwu_lsb_enc.sv
module bwu_lsb_enc #(
   parameter int W = 4,
   localparam int IW = (W > 1) ? $clog2(W) : 1
) (
   input  logic [W-1:0]  vec,
   output logic          any,
   output logic [IW-1:0] idx
);

   always_comb begin
      any = |vec;
      idx = '0;
      for (int i = W - 1; i >= 0; i--) begin
         if (vec[i]) idx = IW'(i);
      end
   end

endmodule

// File: rtl/bwu_match.sv
module bwu_match
   import bwu_pkg::*;
#(
   parameter int AW   = 32,
   parameter int NCLI = 16,
   parameter int NOPS = 4,
   localparam int OPW = $clog2(NOPS),
   localparam int CIW = $clog2(NCLI)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [2:0]      wr_field,
   input  logic [AW-1:0]   wr_data,
   input  logic            acc_valid,
   input  logic [AW-1:0]   acc_addr,
   input  logic [NCLI-1:0] acc_clients,
   input  logic [OPW-1:0]  acc_op,
   output logic            hit,
   output logic [NCLI-1:0] hit_clients,
   output logic [CIW-1:0]  hit_first
);

   logic [AW-1:0]   lo_q;
   logic [AW-1:0]   hi_q;
   logic [NOPS-1:0] ops_q;
   logic [NCLI-1:0] cli_q;
   logic            in_range;
   logic            op_ok;
   logic            cli_any;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lo_q  <= '0;
         hi_q  <= '0;
         ops_q <= '0;
         cli_q <= '0;
      end else if (wr_en) begin
         case (wr_field)
            FLD_LO:  lo_q  <= wr_data;
            FLD_HI:  hi_q  <= wr_data;
            FLD_OPS: ops_q <= wr_data[NOPS-1:0];
            FLD_CLI: cli_q <= wr_data[NCLI-1:0];
            default: ;
         endcase
      end
   end

   always_comb begin
      in_range    = (acc_addr >= lo_q) && (acc_addr < hi_q);
      op_ok       = ops_q[acc_op];
      hit_clients = acc_clients & cli_q;
   end

   bwu_lsb_enc #(.W(NCLI)) u_first (
      .vec (hit_clients),
      .any (cli_any),
      .idx (hit_first)
   );

   assign hit = acc_valid && in_range && op_ok && cli_any;

   // R11
   cfg_lo_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_field == FLD_LO) |=> (lo_q == $past(wr_data)));

   // R11
   cfg_hi_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_field == FLD_HI) |=> (hi_q == $past(wr_data)));

endmodule

// File: rtl/bwu_capture.sv
module bwu_capture #(
   parameter int AW   = 32,
   parameter int NCLI = 16,
   parameter int OPW  = 2,
   parameter int CIW  = 4,
   parameter int SZW  = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            hit,
   input  logic            ack,
   input  logic [AW-1:0]   in_addr,
   input  logic [NCLI-1:0] in_clients,
   input  logic [OPW-1:0]  in_op,
   input  logic [CIW-1:0]  in_first,
   input  logic [SZW-1:0]  in_size,
   output logic            held,
   output logic [AW-1:0]   c_addr,
   output logic [NCLI-1:0] c_clients,
   output logic [OPW-1:0]  c_op,
   output logic [CIW-1:0]  c_first,
   output logic [SZW-1:0]  c_size
);

   logic load;

   assign load = hit && (!held || ack);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held      <= 1'b0;
         c_addr    <= '0;
         c_clients <= '0;
         c_op      <= '0;
         c_first   <= '0;
         c_size    <= '0;
      end else if (load) begin
         held      <= 1'b1;
         c_addr    <= in_addr;
         c_clients <= in_clients;
         c_op      <= in_op;
         c_first   <= in_first;
         c_size    <= in_size;
      end else if (ack) begin
         held      <= 1'b0;
         c_addr    <= '0;
         c_clients <= '0;
         c_op      <= '0;
         c_first   <= '0;
         c_size    <= '0;
      end
   end

   // R6
   frozen_record_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (held && !ack) |=> (held && $stable(c_addr) && $stable(c_clients)
                          && $stable(c_op) && $stable(c_size)));

   // R7
   release_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !hit) |=> (!held && c_addr == '0 && c_clients == '0));

   // R7
   release_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && hit) |=> (held && c_addr == $past(in_addr)));

endmodule

// File: rtl/bwu_irq.sv
module bwu_irq #(
   parameter int NWP = 4,
   localparam int WPW = $clog2(NWP)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NWP-1:0] hit_vec,
   input  logic [NWP-1:0] ack_vec,
   input  logic           mask_we,
   input  logic [NWP-1:0] mask_wdata,
   output logic [NWP-1:0] status,
   output logic           irq,
   output logic           next_valid,
   output logic [WPW-1:0] next_idx
);

   logic [NWP-1:0] pend_q;
   logic [NWP-1:0] mask_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= '0;
         mask_q <= '0;
      end else begin
         pend_q <= (pend_q & ~ack_vec) | hit_vec;
         if (mask_we) mask_q <= mask_wdata;
      end
   end

   assign status = pend_q & mask_q;
   assign irq    = |status;

   bwu_lsb_enc #(.W(NWP)) u_prio (
      .vec (status),
      .any (next_valid),
      .idx (next_idx)
   );

   // R8
   pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|hit_vec) |=> ((pend_q & $past(hit_vec)) == $past(hit_vec)));

   // R8
   pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|(ack_vec & ~hit_vec)) |=> ((pend_q & $past(ack_vec & ~hit_vec)) == '0));

   // R10
   prio_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      next_valid |-> status[next_idx]);

   // R9
   mask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mask_we |=> (mask_q == $past(mask_wdata)));

endmodule

// File: rtl/bus_watch_unit.sv
module bus_watch_unit
   import bwu_pkg::*;
#(
   parameter int NWP  = 4,
   parameter int AW   = 32,
   parameter int NCLI = 16,
   parameter int NOPS = 4,
   parameter int SZW  = 4,
   localparam int WPW = $clog2(NWP),
   localparam int OPW = $clog2(NOPS),
   localparam int CIW = $clog2(NCLI)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cfg_we,
   input  logic [WPW-1:0]  cfg_wp,
   input  logic [2:0]      cfg_field,
   input  logic [AW-1:0]   cfg_wdata,
   input  logic            acc_valid,
   input  logic [AW-1:0]   acc_addr,
   input  logic [NCLI-1:0] acc_clients,
   input  logic [OPW-1:0]  acc_op,
   input  logic [SZW-1:0]  acc_size,
   input  logic [NWP-1:0]  cap_ack,
   input  logic [NWP-1:0]  irq_ack,
   input  logic [WPW-1:0]  rd_sel,
   output logic            rd_held,
   output logic [NCLI-1:0] rd_clients,
   output logic [AW-1:0]   rd_addr,
   output logic [OPW-1:0]  rd_op,
   output logic [CIW-1:0]  rd_first,
   output logic [SZW-1:0]  rd_size,
   output logic [NWP-1:0]  irq_status,
   output logic            irq,
   output logic            irq_next_valid,
   output logic [WPW-1:0]  irq_next_idx
);

   // Elaboration-time parameter checks
   if (NWP < 2 || (NWP & (NWP - 1)) != 0) begin : g_bad_nwp
      $error("NWP must be a power of two of at least 2");
   end
   if (NOPS < 2 || (NOPS & (NOPS - 1)) != 0) begin : g_bad_nops
      $error("NOPS must be a power of two of at least 2");
   end
   if (NCLI < 2 || (NCLI & (NCLI - 1)) != 0) begin : g_bad_ncli
      $error("NCLI must be a power of two of at least 2");
   end
   if (AW < NCLI || AW < NOPS || AW < NWP) begin : g_bad_aw
      $error("AW must be wide enough to carry every mask");
   end

   logic [NWP-1:0]  hit_vec;
   logic [NWP-1:0]  held_vec;
   logic [NCLI-1:0] m_cli   [NWP];
   logic [CIW-1:0]  m_first [NWP];
   logic [AW-1:0]   c_addr  [NWP];
   logic [NCLI-1:0] c_cli   [NWP];
   logic [OPW-1:0]  c_op    [NWP];
   logic [CIW-1:0]  c_first [NWP];
   logic [SZW-1:0]  c_size  [NWP];
   logic            mask_we;

   assign mask_we = cfg_we && (cfg_field == FLD_IMASK);

   for (genvar w = 0; w < NWP; w++) begin : g_wp
      logic wp_we;
      assign wp_we = cfg_we && (cfg_wp == WPW'(w)) && (cfg_field != FLD_IMASK);

      bwu_match #(.AW(AW), .NCLI(NCLI), .NOPS(NOPS)) u_match (
         .clk         (clk),
         .rst_n       (rst_n),
         .wr_en       (wp_we),
         .wr_field    (cfg_field),
         .wr_data     (cfg_wdata),
         .acc_valid   (acc_valid),
         .acc_addr    (acc_addr),
         .acc_clients (acc_clients),
         .acc_op      (acc_op),
         .hit         (hit_vec[w]),
         .hit_clients (m_cli[w]),
         .hit_first   (m_first[w])
      );

      bwu_capture #(.AW(AW), .NCLI(NCLI), .OPW(OPW), .CIW(CIW), .SZW(SZW)) u_cap (
         .clk        (clk),
         .rst_n      (rst_n),
         .hit        (hit_vec[w]),
         .ack        (cap_ack[w]),
         .in_addr    (acc_addr),
         .in_clients (m_cli[w]),
         .in_op      (acc_op),
         .in_first   (m_first[w]),
         .in_size    (acc_size),
         .held       (held_vec[w]),
         .c_addr     (c_addr[w]),
         .c_clients  (c_cli[w]),
         .c_op       (c_op[w]),
         .c_first    (c_first[w]),
         .c_size     (c_size[w])
      );
   end

   bwu_irq #(.NWP(NWP)) u_irq (
      .clk        (clk),
      .rst_n      (rst_n),
      .hit_vec    (hit_vec),
      .ack_vec    (irq_ack),
      .mask_we    (mask_we),
      .mask_wdata (cfg_wdata[NWP-1:0]),
      .status     (irq_status),
      .irq        (irq),
      .next_valid (irq_next_valid),
      .next_idx   (irq_next_idx)
   );

   always_comb begin
      rd_held    = held_vec[rd_sel];
      rd_clients = c_cli[rd_sel];
      rd_addr    = c_addr[rd_sel];
      rd_op      = c_op[rd_sel];
      rd_first   = c_first[rd_sel];
      rd_size    = c_size[rd_sel];
   end

   // R5
   no_strobe_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!acc_valid && held_vec == '0) |=> (held_vec == '0));

   // R9
   irq_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (irq_status != '0));

endmodule

// File: tb/bus_watch_unit_tb_top.sv
`timescale 1ns/1ps
module bus_watch_unit_tb_top;

   localparam int NWP = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_wp = '0;
   logic [2:0]  cfg_field = '0;
   logic [31:0] cfg_wdata = '0;
   logic        acc_valid = 1'b0;
   logic [31:0] acc_addr = '0;
   logic [15:0] acc_clients = '0;
   logic [1:0]  acc_op = '0;
   logic [3:0]  acc_size = '0;
   logic [3:0]  cap_ack = '0;
   logic [3:0]  irq_ack = '0;
   logic [1:0]  rd_sel = '0;
   logic        rd_held;
   logic [15:0] rd_clients;
   logic [31:0] rd_addr;
   logic [1:0]  rd_op;
   logic [3:0]  rd_first;
   logic [3:0]  rd_size;
   logic [3:0]  irq_status;
   logic        irq;
   logic        irq_next_valid;
   logic [1:0]  irq_next_idx;

   always #2 clk = ~clk;

   bus_watch_unit dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wp(cfg_wp),
      .cfg_field(cfg_field), .cfg_wdata(cfg_wdata), .acc_valid(acc_valid),
      .acc_addr(acc_addr), .acc_clients(acc_clients), .acc_op(acc_op),
      .acc_size(acc_size), .cap_ack(cap_ack), .irq_ack(irq_ack),
      .rd_sel(rd_sel), .rd_held(rd_held), .rd_clients(rd_clients),
      .rd_addr(rd_addr), .rd_op(rd_op), .rd_first(rd_first),
      .rd_size(rd_size), .irq_status(irq_status), .irq(irq),
      .irq_next_valid(irq_next_valid), .irq_next_idx(irq_next_idx)
   );

   // Reference model state
   logic [31:0] m_lo [NWP];
   logic [31:0] m_hi [NWP];
   logic [3:0]  m_ops [NWP];
   logic [15:0] m_cli [NWP];
   logic [3:0]  m_mask, m_pend;
   logic        m_held [NWP];
   logic [31:0] m_caddr [NWP];
   logic [15:0] m_ccli [NWP];
   logic [1:0]  m_cop [NWP];
   logic [3:0]  m_cfirst [NWP];
   logic [3:0]  m_csize [NWP];

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   function automatic int lsb(input logic [31:0] v);
      for (int i = 31; i >= 0; i--) if (v[i]) lsb = i;
      if (v == 0) lsb = 0;
   endfunction

   function automatic bit mhit(input int w);
      return acc_valid && (acc_addr >= m_lo[w]) && (acc_addr < m_hi[w])
             && m_ops[w][acc_op] && ((acc_clients & m_cli[w]) != 0);
   endfunction

   task automatic chk(input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic compare(input string tag);
      logic [3:0] st;
      st = m_pend & m_mask;
      chk(tag, "irq_status", 32'(irq_status), 32'(st));
      chk(tag, "irq", 32'(irq), 32'(st != 0));
      chk(tag, "next_valid", 32'(irq_next_valid), 32'(st != 0));
      chk(tag, "next_idx", 32'(irq_next_idx), lsb(32'(st)));
      for (int s = 0; s < NWP; s++) begin
         rd_sel = 2'(s);
         #0.1;
         chk(tag, $sformatf("held[%0d]", s), 32'(rd_held), 32'(m_held[s]));
         chk(tag, $sformatf("addr[%0d]", s), rd_addr, m_caddr[s]);
         chk(tag, $sformatf("clients[%0d]", s), 32'(rd_clients), 32'(m_ccli[s]));
         chk(tag, $sformatf("op[%0d]", s), 32'(rd_op), 32'(m_cop[s]));
         chk(tag, $sformatf("first[%0d]", s), 32'(rd_first), 32'(m_cfirst[s]));
         chk(tag, $sformatf("size[%0d]", s), 32'(rd_size), 32'(m_csize[s]));
      end
   endtask

   // One clock: compute model next state from current inputs, clock, compare
   task automatic step(input string tag);
      logic [3:0] h;
      for (int w = 0; w < NWP; w++) h[w] = mhit(w);
      @(posedge clk);
      for (int w = 0; w < NWP; w++) begin
         if (h[w] && (!m_held[w] || cap_ack[w])) begin
            m_held[w]   = 1'b1;
            m_caddr[w]  = acc_addr;
            m_ccli[w]   = acc_clients & m_cli[w];
            m_cop[w]    = acc_op;
            m_cfirst[w] = 4'(lsb(32'(acc_clients & m_cli[w])));
            m_csize[w]  = acc_size;
         end else if (cap_ack[w]) begin
            m_held[w] = 1'b0; m_caddr[w] = '0; m_ccli[w] = '0;
            m_cop[w] = '0; m_cfirst[w] = '0; m_csize[w] = '0;
         end
      end
      m_pend = (m_pend & ~irq_ack) | h;
      if (cfg_we) begin
         if (cfg_field == 3'd4) m_mask = cfg_wdata[3:0];
         else case (cfg_field)
            3'd0: m_lo[cfg_wp]  = cfg_wdata;
            3'd1: m_hi[cfg_wp]  = cfg_wdata;
            3'd2: m_ops[cfg_wp] = cfg_wdata[3:0];
            3'd3: m_cli[cfg_wp] = cfg_wdata[15:0];
            default: ;
         endcase
      end
      #1;
      compare(tag);
      cfg_we = 0; acc_valid = 0; cap_ack = '0; irq_ack = '0;
   endtask

   task automatic cfg(input int w, input int f, input logic [31:0] d);
      cfg_we = 1; cfg_wp = 2'(w); cfg_field = 3'(f); cfg_wdata = d;
      step("R11 config write");
   endtask

   task automatic acc(input logic [31:0] a, input logic [15:0] c,
                      input logic [1:0] o, input logic [3:0] s, input string tag);
      acc_valid = 1; acc_addr = a; acc_clients = c; acc_op = o; acc_size = s;
      step(tag);
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         n_fail++;
         n_chk++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      m_mask = '0; m_pend = '0;
      for (int w = 0; w < NWP; w++) begin
         m_lo[w] = '0; m_hi[w] = '0; m_ops[w] = '0; m_cli[w] = '0;
         m_held[w] = 0; m_caddr[w] = '0; m_ccli[w] = '0;
         m_cop[w] = '0; m_cfirst[w] = '0; m_csize[w] = '0;
      end
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      compare("R1 reset state");
      // R1: zero bounds cannot hit
      acc(32'h0, 16'hFFFF, 2'd0, 4'd1, "R1 zero config no hit");

      cfg(0, 0, 32'h100);
      cfg(0, 1, 32'h200);
      cfg(0, 2, 32'h2);
      cfg(0, 3, 32'h6);
      cfg(0, 4, 32'h1);
      cfg(2, 7, 32'hFFFF);            // R11 unused code ignored
      acc(32'h100, 16'h000C, 2'd1, 4'd3, "R2 lower bound hit, R3 first client");
      acc(32'h1FF, 16'h0002, 2'd1, 4'd5, "R6 later hit ignored");
      cap_ack = 4'b0001; irq_ack = 4'b0001;
      step("R7 release, R8 clear");
      acc(32'h200, 16'h0002, 2'd1, 4'd1, "R2 upper bound excluded");
      acc(32'h0FF, 16'h0002, 2'd1, 4'd1, "R2 below lower bound");
      acc(32'h150, 16'h0001, 2'd1, 4'd1, "R3 client not watched");
      acc(32'h150, 16'h0002, 2'd0, 4'd1, "R4 kind not watched");
      acc_addr = 32'h150; acc_clients = 16'h0002; acc_op = 2'd1;
      step("R5 no strobe no hit");

      cfg(1, 0, 32'h180);
      cfg(1, 1, 32'h300);
      cfg(1, 2, 32'hF);
      cfg(1, 3, 32'hFFFF);
      cfg(0, 4, 32'h3);
      acc(32'h190, 16'h8002, 2'd1, 4'd2, "R10 both pending, lowest first");
      irq_ack = 4'b0001;
      step("R10 next after clearing 0");
      cfg(0, 4, 32'h1);
      cfg(0, 4, 32'h2);
      step("R9 mask one bit only");
      cap_ack = 4'b0010; irq_ack = 4'b0010;
      acc(32'h2F0, 16'h0100, 2'd3, 4'd7, "R7 ack with hit reloads, R8 set wins");

      for (int i = 0; i < 3000; i++) begin
         if ($urandom_range(0, 9) < 2) begin
            cfg_we = 1; cfg_wp = 2'($urandom);
            cfg_field = 3'($urandom_range(0, 5));
            cfg_wdata = (cfg_field < 2) ? 32'($urandom_range(0, 255)) : $urandom;
         end
         acc_valid = ($urandom_range(0, 9) < 7);
         acc_addr = 32'($urandom_range(0, 255));
         acc_clients = 16'($urandom & $urandom & $urandom);
         acc_op = 2'($urandom);
         acc_size = 4'($urandom);
         for (int w = 0; w < NWP; w++) begin
            cap_ack[w] = ($urandom_range(0, 9) == 0);
            irq_ack[w] = ($urandom_range(0, 9) == 0);
         end
         step("R6 R8 R9 random");
      end

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule